// File: doc/BRIEF.md
# Loop Time-Constant Sequencer for an RDS Demodulator

This block chooses the loop gain of two phase-locked loops in an RDS/RBDS demodulator: the 57 kHz carrier recovery loop and the 1187.5 Hz bit-clock recovery loop. Each loop receives a 2-bit time-constant code. Code 0 is the fastest, widest setting and code 3 is the slowest, most noise-immune setting.

In hardware mode, a resync request restarts a ramp. Both codes drop to 0 and then climb one code for every 64 bit-clock strobes. They reach 3 after 192 strobes, and the ramp counter saturates at the end of its 256-strobe span. Fast loops therefore lock quickly after a tuning change, and slow loops filter noise once the receiver is locked. In software mode, the host drives each loop's code directly and independently, and the ramp is not visible on the outputs.

Top module: `pll_tc_sequencer`

## Requirements
- R1: After reset, in hardware mode (`tc_sw_mode` = 0) and with no resync, both outputs read 3.
- R2: A `resync` pulse sampled in hardware mode makes both outputs read 0 from the following clock edge.
- R3: During a ramp, the code rises by exactly one on the clock edge that samples the 64th `bit_stb` since the previous step. The codes are 0, 1, 2, 3 in that order.
- R4: After 192 strobes since the restart, the code is 3, and it stays 3 under any number of further strobes.
- R5: Clock cycles without `bit_stb` leave the ramp position unchanged.
- R6: A `resync` that arrives partway through a ramp restarts it at code 0, and the full 64 strobes are needed again before code 1.
- R7: In software mode (`tc_sw_mode` = 1), `tc_carrier` equals `sw_tc_carrier` and `tc_bit` equals `sw_tc_bit` in the same cycle. The two are independent of each other.
- R8: A `resync` sampled in software mode has no effect. Returning to hardware mode afterwards with an idle ramp shows 3, not 0.
- R9: Changing from software to hardware mode does not start a ramp by itself. The outputs show 3 until a resync arrives.
- R10: When `resync` and `bit_stb` fall in the same cycle, the restart wins. The strobe is not counted.
- R11: In hardware mode, `tc_carrier` and `tc_bit` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; leaves the ramp idle at the slowest code |
| bit_stb | input | 1 | One-cycle strobe per recovered RDS bit clock |
| resync | input | 1 | One-cycle restart request from block sync or host |
| tc_sw_mode | input | 1 | 0 = hardware ramp, 1 = software-selected codes |
| sw_tc_carrier | input | 2 | Host code for the 57 kHz carrier loop |
| sw_tc_bit | input | 2 | Host code for the bit-clock loop |
| tc_carrier | output | 2 | Time-constant code to the carrier loop |
| tc_bit | output | 2 | Time-constant code to the bit-clock loop |

## Verification
The bench focuses on the step boundaries. It checks the 63rd and 64th strobe of each step. If the boundary is off by one, the code moves one strobe early or late. If the counter does not saturate, the code wraps from 3 back to 0 after 256 strobes.

The bench sends a restart in the middle of a ramp and a restart together with a strobe. A design that only cleared the code would keep its old position within the step. A design that let the strobe win would step up one strobe early.

It also issues resync in software mode and then switches modes. A design that did not gate resync by mode, or that started a ramp on the mode change, would show 0 instead of 3.

// File: rtl/pll_tc_pkg.sv
package pll_tc_pkg;
  typedef enum logic {
    TC_MODE_HW = 1'b0,
    TC_MODE_SW = 1'b1
  } tc_mode_e;

  localparam int unsigned TC_NUM_LOOPS = 2;
  localparam int unsigned TC_LOOP_CARRIER = 0;
  localparam int unsigned TC_LOOP_BIT = 1;
endpackage

// File: rtl/tc_ramp_counter.sv
module tc_ramp_counter #(
  parameter int unsigned STEPS    = 4,
  parameter int unsigned STEP_LEN = 64,
  localparam int unsigned SPAN    = STEPS * STEP_LEN,
  localparam int unsigned CNT_W   = $clog2(SPAN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SPAN - 1);

  logic at_end;
  assign at_end = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= CNT_MAX;
    else if (restart)            cnt <= '0;
    else if (advance && !at_end) cnt <= cnt + CNT_W'(1);
  end

  // R2: a restart leaves the position at the start of the ramp
  a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  // R5: no strobe, no movement
  a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !restart) |=> $stable(cnt));

  // R4: the end of the span is sticky
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !restart) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/tc_code_map.sv
module tc_code_map #(
  parameter int unsigned TC_W     = 2,
  parameter int unsigned STEP_LEN = 64,
  parameter int unsigned CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] cnt,
  output logic [TC_W-1:0]  code
);
  localparam int unsigned STEP_SH = $clog2(STEP_LEN);

  function automatic logic [TC_W-1:0] code_of(input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] shifted;
    shifted = c >> STEP_SH;
    return shifted[TC_W-1:0];
  endfunction

  assign code = code_of(cnt);

  // R3: outside a restart the code only holds or rises by one
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ((code == $past(code)) || (code == $past(code) + TC_W'(1))));
endmodule

// File: rtl/tc_loop_select.sv
module tc_loop_select
  import pll_tc_pkg::*;
#(
  parameter int unsigned TC_W = 2
) (
  input  tc_mode_e        mode,
  input  logic [TC_W-1:0] hw_code,
  input  logic [TC_W-1:0] sw_code,
  output logic [TC_W-1:0] tc
);
  always_comb begin
    unique case (mode)
      TC_MODE_SW: tc = sw_code;
      default:    tc = hw_code;
    endcase
  end
endmodule

// File: rtl/pll_tc_sequencer.sv
module pll_tc_sequencer
  import pll_tc_pkg::*;
#(
  parameter int unsigned TC_W     = 2,
  parameter int unsigned STEPS    = 4,
  parameter int unsigned STEP_LEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_stb,
  input  logic            resync,
  input  logic            tc_sw_mode,
  input  logic [TC_W-1:0] sw_tc_carrier,
  input  logic [TC_W-1:0] sw_tc_bit,
  output logic [TC_W-1:0] tc_carrier,
  output logic [TC_W-1:0] tc_bit
);
  localparam int unsigned CNT_W = $clog2(STEPS * STEP_LEN);

  tc_mode_e        mode;
  logic            restart_evt;
  logic            advance_evt;
  logic [CNT_W-1:0] ramp_cnt;
  logic [TC_W-1:0] hw_code;
  logic [TC_W-1:0] sw_codes [TC_NUM_LOOPS];
  logic [TC_W-1:0] loop_tc  [TC_NUM_LOOPS];

  assign mode        = tc_mode_e'(tc_sw_mode);
  assign restart_evt = resync && (mode == TC_MODE_HW);
  assign advance_evt = bit_stb;

  assign sw_codes[TC_LOOP_CARRIER] = sw_tc_carrier;
  assign sw_codes[TC_LOOP_BIT]     = sw_tc_bit;

  tc_ramp_counter #(.STEPS(STEPS), .STEP_LEN(STEP_LEN)) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart_evt),
    .advance (advance_evt),
    .cnt     (ramp_cnt)
  );

  tc_code_map #(.TC_W(TC_W), .STEP_LEN(STEP_LEN), .CNT_W(CNT_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart_evt),
    .cnt     (ramp_cnt),
    .code    (hw_code)
  );

  for (genvar g = 0; g < TC_NUM_LOOPS; g++) begin : g_loop
    tc_loop_select #(.TC_W(TC_W)) u_sel (
      .mode    (mode),
      .hw_code (hw_code),
      .sw_code (sw_codes[g]),
      .tc      (loop_tc[g])
    );
  end

  assign tc_carrier = loop_tc[TC_LOOP_CARRIER];
  assign tc_bit     = loop_tc[TC_LOOP_BIT];

  // R11: in hardware mode both loops follow the same ramp
  a_r11_loops_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_sw_mode |-> (tc_carrier == tc_bit));

  // R8: resync seen in software mode must not move the ramp
  a_r8_sw_resync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_sw_mode && resync && !bit_stb) |=> $stable(ramp_cnt));
endmodule

// File: tb/pll_tc_sequencer_tb_top.sv
module pll_tc_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0;
  logic       resync = 1'b0;
  logic       tc_sw_mode = 1'b0;
  logic [1:0] sw_tc_carrier = 2'd0;
  logic [1:0] sw_tc_bit = 2'd0;
  logic [1:0] tc_carrier;
  logic [1:0] tc_bit;

  always #10 clk = ~clk;

  pll_tc_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .resync(resync),
    .tc_sw_mode(tc_sw_mode), .sw_tc_carrier(sw_tc_carrier), .sw_tc_bit(sw_tc_bit),
    .tc_carrier(tc_carrier), .tc_bit(tc_bit)
  );

  typedef struct {
    logic [1:0] exp_c;
    logic [1:0] exp_b;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   m_pos = 255;   // independent model of the ramp position
  bit   done = 0;

  function automatic logic [1:0] model_code(input int pos);
    return 2'(pos / 64);
  endfunction

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic apply(input logic stb, input logic rs, input logic md,
                       input logic [1:0] sc, input logic [1:0] sb, input string tag);
    exp_t e;
    @(negedge clk);
    bit_stb = stb; resync = rs; tc_sw_mode = md;
    sw_tc_carrier = sc; sw_tc_bit = sb;
    @(posedge clk);
    if (!md && rs)                 m_pos = 0;
    else if (stb && m_pos < 255)   m_pos = m_pos + 1;
    e.exp_c = md ? sc : model_code(m_pos);
    e.exp_b = md ? sb : model_code(m_pos);
    e.tag   = tag;
    q.push_back(e);
  endtask

  task automatic strobes(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      apply(1'b1, 1'b0, 1'b0, 2'd0, 2'd0, tag);
      apply(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, "R5");
    end
  endtask

  // monitor: compare a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (tc_carrier !== e.exp_c || tc_bit !== e.exp_b) begin
          n_bad++;
          $display("FAIL %s: carrier=%0d bit=%0d expected carrier=%0d bit=%0d",
                   e.tag, tc_carrier, tc_bit, e.exp_c, e.exp_b);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: idle after reset
    for (int i = 0; i < 3; i++) apply(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, "R1");
    // R7: software codes, independent per loop
    apply(1'b0, 1'b0, 1'b1, 2'd0, 2'd3, "R7");
    apply(1'b0, 1'b0, 1'b1, 2'd2, 2'd1, "R7");
    apply(1'b1, 1'b0, 1'b1, 2'd3, 2'd0, "R7");
    // R8: resync in software mode is ignored
    apply(1'b0, 1'b1, 1'b1, 2'd1, 2'd2, "R8");
    apply(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, "R8");
    // R9: mode change alone starts nothing
    apply(1'b0, 1'b0, 1'b1, 2'd0, 2'd0, "R9");
    apply(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, "R9");
    apply(1'b1, 1'b0, 1'b0, 2'd0, 2'd0, "R9");
    // R2: restart in hardware mode
    apply(1'b0, 1'b1, 1'b0, 2'd0, 2'd0, "R2");
    // R3, R11: walk the full ramp with gaps between strobes
    strobes(63, "R3");
    strobes(1,  "R3");
    strobes(127, "R11");
    strobes(1,  "R4");
    // R4: saturation past the span end
    strobes(80, "R4");
    // R6: restart mid-ramp
    apply(1'b0, 1'b1, 1'b0, 2'd0, 2'd0, "R2");
    strobes(100, "R6");
    apply(1'b0, 1'b1, 1'b0, 2'd0, 2'd0, "R6");
    strobes(63, "R6");
    strobes(1,  "R6");
    // R10: restart and strobe together
    strobes(10, "R10");
    apply(1'b1, 1'b1, 1'b0, 2'd0, 2'd0, "R10");
    strobes(63, "R10");
    strobes(1,  "R10");
    // R7 after a ramp: software still overrides
    apply(1'b0, 1'b0, 1'b1, 2'd3, 2'd1, "R7");
    apply(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, "R11");
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule